// File: doc/BRIEF.md
# Reset-Time Strap Sampler and Pin Direction Controller

This block lets a few multipurpose device pins serve as configuration straps while the device is in reset. The straps are then handed back as ordinary inputs or outputs once reset is over. A reset request comes from the external active-low reset pin, passed through a two-flop synchroniser, or from a register write that requests a soft reset. After a request is seen, the pins keep their current drive for a fixed delay of 16 µs, counted in system clocks. They then enter high impedance with weak pull-ups enabled.

While the pins float in that state, the block samples them on every clock. A pin that is pulled low externally marks a non-default choice. One strap pin selects the host interface: low selects SPI, high selects UART. A second strap pin selects the oscillator option: low selects the 32 kHz crystal, high selects the high-frequency crystal. When the reset request goes away, the block waits a second 16 µs delay. It then turns the pull-ups off and enables the pin drivers that the latched host-interface mode calls for.

If reset returns during that second delay, the hand-back is abandoned and the pins stay floating. The latched mode bits are held constant from the hand-back until the next reset. Pad circuitry sits outside the block.

Top module: `strap_pin_ctrl`

## Requirements
- R1: While the synchronous system reset `rst_n` is low, every `pin_pu` bit is 1, every `pin_oe` bit is 0, and `host_spi` and `osc_32k` are 0. After `rst_n` is released, the pins stay floating and keep sampling until no reset request is present.
- R2: A low level on `rst_pin_n` is seen through two synchroniser flops. The pins keep their driven state for DELAY_CYC = CLK_MHZ*DELAY_US cycles (800 by default). After that, every pin has `pin_oe`=0 and `pin_pu`=1.
- R3: On every clock in the floating phase, the strap pins are sampled. `host_spi` becomes 1 when the pin selected by SPI_STRAP_SEL (pin 0) is low. `osc_32k` becomes 1 when the pin selected by OSC_STRAP_SEL (pin 1) is low. The value that counts is the one captured on the last floating-phase clock before the release delay starts.
- R4: Once no reset request is present, the pins stay floating for DELAY_CYC more cycles. After that, `pin_pu` is all 0 and `pin_oe` equals OE_UART (4'b1011) when `host_spi`=0, or OE_SPI (4'b0101) when `host_spi`=1.
- R5: If a reset request returns before the release delay ends, the pins stay floating. A full DELAY_CYC is then counted again after the next release.
- R6: A write with `reg_wr_en`=1, `reg_wr_addr`=8'h6E and `reg_wr_data` bit 4 = 1 raises an internal reset request for SOFT_CYC cycles. This request runs the same sequence as a pin reset. A write to any other address, or with bit 4 clear, has no effect.
- R7: Changes of strap pin levels outside the floating phase are ignored. `host_spi` and `osc_32k` never change while the pins are driven.
- R8: No pin ever has its output enable and its pull-up enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| rst_pin_n | input | 1 | External active-low reset pin, asynchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| pin_in | input | NPINS | Pad input levels of the strap-capable pins |
| pin_oe | output | NPINS | Per-pin output driver enable |
| pin_pu | output | NPINS | Per-pin weak pull-up enable |
| host_spi | output | 1 | Latched host interface, 1 = SPI, 0 = UART |
| osc_32k | output | 1 | Latched oscillator option, 1 = 32 kHz crystal |

## Verification
The bench checks that the pins go on driving for the whole entry delay after the reset pin falls. A design that counted the delay from the raw pin would float them early. A design that ignored the delay would float them at once.

It re-asserts reset partway through the release delay. A design that failed to abort would hand the pins back too soon. A design that failed to restart the count would hand them back short of a full delay.

It also checks that strap levels changing while the pins are driven leave the mode bits alone. It checks that near-miss register writes, with the wrong address or with bit 4 clear, leave the pins driven. A design that decoded too loosely would drop the pins into the floating state.

// File: rtl/strap_pkg.sv
// Package: shared phase encoding and latched-mode type for the strap
// controller. Assumes no more than four sequencing phases.
package strap_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,  // pins driven per latched mode
        PH_ENTER = 2'd1,  // reset seen, counting before float
        PH_FLOAT = 2'd2,  // pins floating with pull-ups, sampling straps
        PH_LEAVE = 2'd3   // reset gone, counting before hand-back
    } phase_e;

    typedef struct packed {
        logic spi;    // 1 = SPI host interface
        logic osc32;  // 1 = 32 kHz crystal
    } strap_mode_t;

endpackage

// File: rtl/strap_rst_req.sv
// Reset request source: synchronises the external reset pin through two
// flops and stretches a soft-reset register write into a fixed-length
// request. Assumes the write strobe is synchronous to clk.
module strap_rst_req #(
    parameter int          SOFT_CYC   = 32,
    parameter logic [7:0]  SOFT_ADDR  = 8'h6E,
    parameter logic [7:0]  SOFT_BIT   = 8'h10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_pin_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_addr,
    input  logic [7:0] reg_wr_data,
    output logic       req
);
    localparam int SW = $clog2(SOFT_CYC + 1);
    localparam logic [SW-1:0] SOFT_LOAD = SW'(SOFT_CYC);

    logic [1:0]    sync_q;
    logic [SW-1:0] soft_cnt;
    logic          soft_hit;

    // Decode a write that requests a soft reset.
    always_comb begin
        soft_hit = reg_wr_en && (reg_wr_addr == SOFT_ADDR) &&
                   ((reg_wr_data & SOFT_BIT) != 8'h00);
    end

    // Two-flop synchroniser; resets to "asserted" so power-up floats.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], rst_pin_n};
    end

    // Soft reset stretch counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             soft_cnt <= '0;
        else if (soft_hit)      soft_cnt <= SOFT_LOAD;
        else if (soft_cnt != 0) soft_cnt <= soft_cnt - 1'b1;
    end

    assign req = !sync_q[1] || (soft_cnt != '0);

endmodule

// File: rtl/strap_seq.sv
// Phase sequencer: walks run -> enter delay -> float -> leave delay -> run.
// A request during the leave delay returns to float. Assumes DELAY_CYC >= 2.
module strap_seq
    import strap_pkg::*;
#(
    parameter int DELAY_CYC = 800
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    output phase_e phase
);
    localparam int CW = $clog2(DELAY_CYC);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    // Phase register and delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FLOAT;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_RUN: begin
                    cnt_q <= '0;
                    if (req) phase_q <= PH_ENTER;
                end
                PH_ENTER: begin
                    if (cnt_q == LAST) begin
                        phase_q <= PH_FLOAT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FLOAT: begin
                    cnt_q <= '0;
                    if (!req) phase_q <= PH_LEAVE;
                end
                default: begin
                    if (req) begin
                        phase_q <= PH_FLOAT;
                        cnt_q   <= '0;
                    end else if (cnt_q == LAST) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/strap_latch.sv
// Strap latch: captures the strap pins on each clock of the float phase;
// holds otherwise. A low pin selects the non-default option. Assumes each
// select mask is one-hot.
module strap_latch
    import strap_pkg::*;
#(
    parameter int               NPINS         = 4,
    parameter logic [NPINS-1:0] SPI_STRAP_SEL = 4'b0001,
    parameter logic [NPINS-1:0] OSC_STRAP_SEL = 4'b0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [NPINS-1:0] pin_in,
    output strap_mode_t      mode
);
    strap_mode_t mode_q;

    // Sample straps while floating, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (sample_en) begin
            mode_q.spi   <= ~|(pin_in & SPI_STRAP_SEL);
            mode_q.osc32 <= ~|(pin_in & OSC_STRAP_SEL);
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/strap_pin_ctrl.sv
// Top: strap sampler and pin-mode controller. Combines the reset request
// source, phase sequencer and strap latch, and decodes per-pin output
// enables and pull-ups. Assumes pads implement the oe/pu controls.
module strap_pin_ctrl
    import strap_pkg::*;
#(
    parameter int               NPINS         = 4,
    parameter int               CLK_MHZ       = 50,
    parameter int               DELAY_US      = 16,
    parameter int               SOFT_CYC      = 32,
    parameter logic [NPINS-1:0] SPI_STRAP_SEL = 4'b0001,
    parameter logic [NPINS-1:0] OSC_STRAP_SEL = 4'b0010,
    parameter logic [NPINS-1:0] OE_UART       = 4'b1011,
    parameter logic [NPINS-1:0] OE_SPI        = 4'b0101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_pin_n,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_wr_addr,
    input  logic [7:0]       reg_wr_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pu,
    output logic             host_spi,
    output logic             osc_32k
);
    localparam int DELAY_CYC = CLK_MHZ * DELAY_US;

    logic        req;
    phase_e      phase;
    strap_mode_t mode;
    logic        driving;
    logic        floating;

    strap_rst_req #(
        .SOFT_CYC (SOFT_CYC)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_pin_n   (rst_pin_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .req         (req)
    );

    strap_seq #(
        .DELAY_CYC (DELAY_CYC)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .phase (phase)
    );

    strap_latch #(
        .NPINS         (NPINS),
        .SPI_STRAP_SEL (SPI_STRAP_SEL),
        .OSC_STRAP_SEL (OSC_STRAP_SEL)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (phase == PH_FLOAT),
        .pin_in    (pin_in),
        .mode      (mode)
    );

    // Phase-level drive and float qualifiers.
    always_comb begin
        driving  = (phase == PH_RUN) || (phase == PH_ENTER);
        floating = !driving;
    end

    // Per-pin decode of driver enable and pull-up.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_comb begin
            pin_oe[i] = driving && (mode.spi ? OE_SPI[i] : OE_UART[i]);
            pin_pu[i] = floating;
        end
    end

    assign host_spi = mode.spi;
    assign osc_32k  = mode.osc32;

endmodule

// File: rtl/strap_pin_ctrl_chk.sv
// Checker for strap_pin_ctrl, attached by bind. Assumes the port-level
// view only; counts quiet reset-pin cycles to bound the hand-back.
module strap_pin_ctrl_chk #(
    parameter int               NPINS     = 4,
    parameter int               DELAY_CYC = 800,
    parameter logic [NPINS-1:0] OE_UART   = 4'b1011,
    parameter logic [NPINS-1:0] OE_SPI    = 4'b0101
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_pin_n,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] pin_pu,
    input logic             host_spi,
    input logic             osc_32k
);
    int quiet;

    // Count consecutive cycles with the reset pin released.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_pin_n) quiet <= 0;
        else if (quiet < DELAY_CYC + 4) quiet <= quiet + 1;
    end

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_pu) == '0);

    assert_pullup_all_or_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu == '0) || (pin_pu == '1));

    assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu == '0) |=> $stable({host_spi, osc_32k}));

    assert_handback_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_pu[0]) |-> (pin_oe == (host_spi ? OE_SPI : OE_UART)));

    assert_release_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_pu[0]) |-> (quiet >= DELAY_CYC));

endmodule

bind strap_pin_ctrl strap_pin_ctrl_chk #(
    .NPINS     (NPINS),
    .DELAY_CYC (CLK_MHZ * DELAY_US),
    .OE_UART   (OE_UART),
    .OE_SPI    (OE_SPI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_pin_n (rst_pin_n),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu),
    .host_spi  (host_spi),
    .osc_32k   (osc_32k)
);

// File: tb/strap_pin_ctrl_tb.sv
// Bench: behavioural per-clock reference model plus directed checks.
module strap_pin_ctrl_tb;
    localparam int D    = 800;
    localparam int SOFT = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rst_pin_n;
    logic       reg_wr_en;
    logic [7:0] reg_wr_addr;
    logic [7:0] reg_wr_data;
    logic [3:0] pin_in;
    logic [3:0] pin_oe;
    logic [3:0] pin_pu;
    logic       host_spi;
    logic       osc_32k;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    strap_pin_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_pin_n   (rst_pin_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .pin_in      (pin_in),
        .pin_oe      (pin_oe),
        .pin_pu      (pin_pu),
        .host_spi    (host_spi),
        .osc_32k     (osc_32k)
    );

    // Reference model: pin history queue, soft timer, phase and delay count.
    bit pin_hist[$];
    int m_soft, m_phase, m_cnt;   // phase: 0 drive, 1 pre-float, 2 float, 3 pre-drive
    bit m_spi, m_osc;

    always @(posedge clk) begin
        bit req;
        if (!rst_n) begin
            pin_hist = '{0, 0};
            m_soft = 0; m_phase = 2; m_cnt = 0; m_spi = 0; m_osc = 0;
        end else begin
            req = !pin_hist[0] || (m_soft > 0);
            if (m_phase == 2) begin
                m_spi = !pin_in[0];
                m_osc = !pin_in[1];
            end
            case (m_phase)
                0: begin m_cnt = 0; if (req) m_phase = 1; end
                1: if (m_cnt == D - 1) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
                2: begin m_cnt = 0; if (!req) m_phase = 3; end
                default:
                    if (req) begin m_phase = 2; m_cnt = 0; end
                    else if (m_cnt == D - 1) begin m_phase = 0; m_cnt = 0; end
                    else m_cnt++;
            endcase
            if (reg_wr_en && reg_wr_addr == 8'h6E && reg_wr_data[4]) m_soft = SOFT;
            else if (m_soft > 0) m_soft--;
            void'(pin_hist.pop_front());
            pin_hist.push_back(rst_pin_n);
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        logic [3:0] e_oe, e_pu;
        if (!done) begin
            e_oe = (m_phase <= 1) ? (m_spi ? 4'b0101 : 4'b1011) : 4'b0000;
            e_pu = (m_phase >= 2) ? 4'b1111 : 4'b0000;
            vectors++;
            if (pin_oe !== e_oe) begin
                fails++;
                $display("FAIL R4 pin_oe actual %b expected %b at %0t", pin_oe, e_oe, $time);
            end
            if (pin_pu !== e_pu) begin
                fails++;
                $display("FAIL R2 pin_pu actual %b expected %b at %0t", pin_pu, e_pu, $time);
            end
            if (host_spi !== m_spi || osc_32k !== m_osc) begin
                fails++;
                $display("FAIL R3 mode actual %b%b expected %b%b at %0t",
                         host_spi, osc_32k, m_spi, m_osc, $time);
            end
        end
    end

    task automatic check(input string req, input logic [3:0] oe, input logic [3:0] pu,
                         input logic spi, input logic osc);
        vectors++;
        if (pin_oe !== oe || pin_pu !== pu || host_spi !== spi || osc_32k !== osc) begin
            fails++;
            $display("FAIL %s actual oe=%b pu=%b spi=%b osc=%b expected oe=%b pu=%b spi=%b osc=%b",
                     req, pin_oe, pin_pu, host_spi, osc_32k, oe, pu, spi, osc);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; rst_pin_n = 1'b0; reg_wr_en = 1'b0;
        reg_wr_addr = 8'h00; reg_wr_data = 8'h00;
        pin_in = 4'b1110;                          // pin0 low: SPI, pin1 high: fast crystal
        cycles(5);
        check("R1 reset state", 4'b0000, 4'b1111, 1'b0, 1'b0);
        rst_n = 1'b1;
        cycles(20);
        check("R1 float after reset", 4'b0000, 4'b1111, 1'b1, 1'b0);
        rst_pin_n = 1'b1;
        cycles(D - 20);
        check("R4 still floating in release delay", 4'b0000, 4'b1111, 1'b1, 1'b0);
        cycles(40);
        check("R4 SPI hand-back", 4'b0101, 4'b0000, 1'b1, 1'b0);

        pin_in = 4'b0000;                          // strap changes while driven
        cycles(10);
        check("R7 strap change ignored", 4'b0101, 4'b0000, 1'b1, 1'b0);

        pin_in = 4'b1101;                          // pin0 high: UART, pin1 low: 32 kHz
        rst_pin_n = 1'b0;
        cycles(D / 2);
        check("R2 still driven in entry delay", 4'b0101, 4'b0000, 1'b1, 1'b0);
        cycles(D / 2 + 20);
        check("R2 floating after entry delay", 4'b0000, 4'b1111, 1'b0, 1'b1);
        rst_pin_n = 1'b1;
        cycles(D / 2);
        rst_pin_n = 1'b0;                          // abort hand-back
        cycles(30);
        check("R5 abort keeps float", 4'b0000, 4'b1111, 1'b0, 1'b1);
        rst_pin_n = 1'b1;
        cycles(D - 20);
        check("R5 full delay restarted", 4'b0000, 4'b1111, 1'b0, 1'b1);
        cycles(40);
        check("R3 R4 UART and 32k hand-back", 4'b1011, 4'b0000, 1'b0, 1'b1);

        pin_in = 4'b1110;
        write(8'h6E, 8'hEF);                       // bit 4 clear
        write(8'h6F, 8'h10);                       // wrong address
        cycles(D + 20);
        check("R6 near-miss writes ignored", 4'b1011, 4'b0000, 1'b0, 1'b1);

        write(8'h6E, 8'h10);                       // soft reset
        cycles(D + 20);
        check("R6 soft reset floats pins", 4'b0000, 4'b1111, 1'b1, 1'b0);
        cycles(D + 20);
        check("R6 soft reset hands back SPI", 4'b0101, 4'b0000, 1'b1, 1'b0);
        check("R8 no drive with pull-up", 4'b0101, 4'b0000, 1'b1, 1'b0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule